// File: doc/BRIEF.md
# Compare-Match Pulse Timer

A free-running up-counter with a compare register that emits a single-tick output pulse. While the block is enabled in pulse mode, the counter starts from a programmed load value and advances on every timer tick. When the count becomes equal to the compare value, three things happen. The output pin is driven to the opposite of its idle level for one tick period. A sticky status flag is raised. An interrupt request follows if interrupts are enabled.

After a match, one control bit selects what the counter does next. It either loads the load value again on the following tick, which gives a periodic pulse train with a period of (compare − load + 1) ticks. Or it keeps counting upward and wraps through zero. The tick is derived from the system clock in one of two ways: every second clock, or every 256th clock through an 8-bit prescaler.

Top module: `pt_cmp_timer`

## Requirements
- R1: After reset: `cnt_o` is 0, `cmp_flag_o` and `irq_o` are 0, and `pulse_o` equals `inv_i`.
- R2: While the timer is not running, the counter holds its value and `pulse_o` equals `inv_i`. The timer is not running when `en_i` is 0 or when `mode_i` is not 4'b0001.
- R3: The timer starts on the first clock edge where it is running. At that edge `cnt_o` takes `load_i`. With `psc_sel_i` = 0, a tick occurs on every second edge after the start edge, and each tick adds one to the count.
- R4: With `psc_sel_i` = 1, a tick occurs on every 256th edge after the start edge.
- R5: The counter can take a value equal to `cmp_i`, either at start or on a tick. From then until the next tick, `pulse_o` equals the inverse of `inv_i`.
- R6: With `reload_i` = 1, the tick that follows a match loads `load_i` into the counter instead of incrementing it.
- R7: With `reload_i` = 0, the counter keeps incrementing after a match. It wraps from 24'hFFFFFF to 0.
- R8: `cmp_flag_o` is set on a match and stays set until a cycle with `flag_clr_i` = 1 clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: `irq_o` equals `cmp_flag_o` AND `irq_en_i`.
- R10: Dropping `en_i` returns `pulse_o` to `inv_i` in the same cycle and freezes the counter. The next enable restarts both the count from `load_i` and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| mode_i | input | 4 | Mode field; 4'b0001 selects pulse mode |
| inv_i | input | 1 | Idle level of the output pin |
| reload_i | input | 1 | Reload counter from load value after a match |
| irq_en_i | input | 1 | Interrupt enable |
| psc_sel_i | input | 1 | 0: tick = clock/2, 1: tick = clock/256 |
| load_i | input | 24 | Load (start) value |
| cmp_i | input | 24 | Compare value |
| flag_clr_i | input | 1 | Write-one-to-clear for the compare flag |
| pulse_o | output | 1 | Pulse output pin |
| cmp_flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| cnt_o | output | 24 | Current counter value |

## Verification
The pulse function is swept over every load/compare pair with a distance of 0 to 3. Both idle levels and both interrupt settings are covered. This separates an off-by-one in the start load from one in the compare or in the reload period, and it covers the case where the start value already matches. Continuous-count runs use one pair that goes through the match and another that wraps through all-ones. These show whether the reload bit is honoured and whether the wrap is correct. One run with the divide-by-256 prescaler confirms the tick spacing and the prescaler restart. Disable and wrong-mode phases check that the pin drops to its idle level at once and that the count is frozen.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam logic [3:0] MODE_PULSE = 4'b0001;
  localparam int unsigned CNT_W_DEF = 24;
  localparam int unsigned PSC_W_DEF = 8;
endpackage

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
  parameter int unsigned PSC_W = pt_pkg::PSC_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic psc_sel_i,
  output logic tick_o
);
  logic [PSC_W-1:0] div_q;

  // divider restarts from zero whenever the timer is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + PSC_W'(1);
  end

  assign tick_o = run_i & (psc_sel_i ? (&div_q) : div_q[0]);
endmodule

// File: rtl/pt_count_core.sv
module pt_count_core #(
  parameter int unsigned CNT_W = pt_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, next_val;
  logic             hit_q, run_q, start;

  assign start    = run_i & ~run_q;
  assign next_val = (hit_q & reload_i) ? load_i : cnt_q + CNT_W'(1);
  assign match_o  = run_i & ((start & (load_i == cmp_i)) |
                             (~start & tick_i & (next_val == cmp_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        hit_q <= 1'b0;
      end else if (start) begin
        cnt_q <= load_i;
        hit_q <= (load_i == cmp_i);
      end else if (tick_i) begin
        cnt_q <= next_val;
        hit_q <= (next_val == cmp_i);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/pt_flag.sv
module pt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pt_cmp_timer.sv
module pt_cmp_timer #(
  parameter int unsigned CNT_W = pt_pkg::CNT_W_DEF,
  parameter int unsigned PSC_W = pt_pkg::PSC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       mode_i,
  input  logic             inv_i,
  input  logic             reload_i,
  input  logic             irq_en_i,
  input  logic             psc_sel_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             flag_clr_i,
  output logic             pulse_o,
  output logic             cmp_flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic run, tick, hit, match;

  assign run = en_i & (mode_i == pt_pkg::MODE_PULSE);

  pt_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .psc_sel_i, .tick_o(tick)
  );

  pt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .reload_i,
    .load_i, .cmp_i, .cnt_o, .hit_o(hit), .match_o(match)
  );

  pt_flag u_flag (
    .clk_i, .rst_ni, .set_i(match), .clr_i(flag_clr_i), .flag_o(cmp_flag_o)
  );

  // idle level restored combinationally on disable
  assign pulse_o = inv_i ^ (hit & run);
  assign irq_o   = cmp_flag_o & irq_en_i;
endmodule

// File: rtl/pt_cmp_timer_chk.sv
module pt_cmp_timer_chk #(
  parameter int unsigned CNT_W = pt_pkg::CNT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [3:0]       mode_i,
  input logic             inv_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic             pulse_o,
  input logic             cmp_flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_o
);
  logic running;
  assign running = en_i && (mode_i == pt_pkg::MODE_PULSE);

  p_idle_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> (pulse_o == inv_i));

  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> $stable(cnt_o));

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_o && !flag_clr_i) |=> cmp_flag_o);

  p_pulse_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $rose(pulse_o ^ inv_i)) |-> cmp_flag_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cmp_flag_o && irq_en_i));
endmodule

bind pt_cmp_timer pt_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .inv_i(inv_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
  .pulse_o(pulse_o), .cmp_flag_o(cmp_flag_o), .irq_o(irq_o), .cnt_o(cnt_o)
);

// File: tb/pt_cmp_timer_test.sv
module pt_cmp_timer_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        en_i = 0, inv_i = 0, reload_i = 0, irq_en_i = 0, psc_sel_i = 0, flag_clr_i = 0;
  logic [3:0]  mode_i = 4'd1;
  logic [23:0] load_i = '0, cmp_i = '0;
  logic        pulse_o, cmp_flag_o, irq_o;
  logic [23:0] cnt_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pt_cmp_timer uut (
    .clk_i(clk), .rst_ni, .en_i, .mode_i, .inv_i, .reload_i, .irq_en_i,
    .psc_sel_i, .load_i, .cmp_i, .flag_clr_i, .pulse_o, .cmp_flag_o,
    .irq_o, .cnt_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one enable run; expected values from tick count k
  task automatic run_case(logic [23:0] n, logic [23:0] m, bit rl, bit iv,
                          bit ie, bit ps, int len);
    logic [23:0] diff;
    @(negedge clk);
    en_i = 0; flag_clr_i = 1;
    @(negedge clk);
    flag_clr_i = 0;
    chk("R8", cmp_flag_o, 0);
    load_i = n; cmp_i = m; reload_i = rl; inv_i = iv; irq_en_i = ie;
    psc_sel_i = ps; mode_i = 4'd1; en_i = 1;
    diff = m - n;
    for (int t = 0; t < len; t++) begin
      int k;
      logic [23:0] ec;
      bit eh, ef;
      @(negedge clk);
      k = ps ? (t + 1) / 256 : (t + 1) / 2;
      if (rl) begin
        int r;
        r  = k % (int'(diff) + 1);
        ec = n + 24'(r);
        eh = (r == int'(diff));
      end else begin
        ec = n + 24'(k);
        eh = (ec == m);
      end
      ef = (k >= int'(diff));
      chk(ps ? "R4" : (rl ? "R6" : "R7"), cnt_o, ec);
      chk("R5", pulse_o, iv ^ eh);
      chk("R8", cmp_flag_o, ef);
      chk("R9", irq_o, ef & ie);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    inv_i = 1;
    #20;
    // R1 reset values
    chk("R1", cnt_o, 0);
    chk("R1", pulse_o, 1);
    chk("R1", cmp_flag_o, 0);
    chk("R1", irq_o, 0);
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    chk("R1", cnt_o, 0);

    // R3 R5 R6 sweep over start/compare distances
    for (int n = 0; n < 4; n++)
      for (int d = 0; d < 4; d++)
        run_case(24'(n), 24'(n + d), 1, (n + d) % 2 == 1, d % 2 == 0, 0, 4 * (d + 1) * 2 + 2);

    // R7 continuous count through match, and wrap through all-ones
    run_case(24'd10, 24'd13, 0, 0, 1, 0, 16);
    run_case(24'hFFFFFE, 24'd1, 0, 1, 1, 0, 12);

    // R4 prescaled tick
    run_case(24'd5, 24'd7, 1, 0, 1, 1, 256 * 7);

    // R10 disable during pulse
    run_case(24'd0, 24'd2, 1, 1, 0, 0, 4);
    chk("R5", pulse_o, 0);
    en_i = 0;
    #1;
    chk("R10", pulse_o, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", cnt_o, 2);
      chk("R2", pulse_o, 1);
    end
    // R2 wrong mode: no counting
    mode_i = 4'd2; en_i = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2", cnt_o, 2);
      chk("R2", pulse_o, 1);
    end
    // R8 flag held without clear, then clear
    chk("R8", cmp_flag_o, 1);
    flag_clr_i = 1;
    @(negedge clk);
    flag_clr_i = 0;
    chk("R8", cmp_flag_o, 0);
    // R10 restart from load value
    run_case(24'd3, 24'd5, 1, 0, 1, 0, 14);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule